// File: doc/BRIEF.md
# Doorbell and Interrupt Register Block

This block is a small memory-mapped register slave for a node that shares memory with peer nodes. It keeps a 32-bit interrupt mask and a 32-bit interrupt status, and raises a level interrupt whenever a set status bit is also enabled in the mask. Reading the status register hands back its contents and empties it in the same access, so software acknowledges every pending cause with one read. An event port lets the surrounding logic load a new byte-wide cause into the status register at any time.

The block also answers a read of the node's own position, returning the node identifier only once the shared region is mapped. Writes to the doorbell register name a destination peer and a vector. The block checks both against the current peer population and against the number of vectors that peer has registered. Only a doorbell that passes both checks produces a notify pulse, and that pulse carries the decoded destination and vector for the transport logic.

Top module: `doorbell_irq_regs`

## Requirements
- R1: The word index is busAddr[7:2] and busAddr[1:0] is ignored. Index 0 is the mask, 1 the status, 2 the position and 3 the doorbell. busRdata is combinational during a read access (busSel=1, busWrite=0) and is zero at all other times.
- R2: Reset clears the mask and the status, so irq is low after reset.
- R3: irq is high exactly when (status AND mask) is nonzero, evaluated on the register values after the clock edge that ends each access.
- R4: A status read returns the current status value. Unless an event arrives in the same cycle, the status is zero after that access.
- R5: A doorbell write takes the destination from busWdata[31:16] and the vector from busWdata[7:0], and ignores busWdata[15:8]. When the doorbell is accepted, notifyPulse is high for that same access cycle only, with notifyDest and notifyVec showing the fields. When notifyPulse is low, both are zero.
- R6: A doorbell whose destination is greater than or equal to peerCount, or greater than or equal to the NUM_PEERS parameter, produces no pulse.
- R7: A doorbell whose vector is greater than or equal to the destination's registered count produces no pulse. The count for peer p is peerVecCnt[p*CNT_W +: CNT_W].
- R8: A position read returns localId zero-extended when regionMapped is 1, and 32'hFFFF_FFFF otherwise.
- R9: Reads of indices 4 to 63 return zero. Writes to those indices and to the position register leave the mask and status unchanged.
- R10: evtValid loads the status with evtByte zero-extended to 32 bits at the next clock edge.
- R11: When evtValid coincides with a status read or a status write, the event byte is what the status holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte address in the register window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| peerCount | input | 16 | Number of valid peers |
| peerVecCnt | input | NUM_PEERS*CNT_W | Registered vector count for each peer, packed |
| regionMapped | input | 1 | Shared region is mapped |
| localId | input | 16 | Local node identifier |
| evtValid | input | 1 | Inject event byte into status |
| evtByte | input | 8 | Event byte |
| irq | output | 1 | Level interrupt |
| notifyPulse | output | 1 | Accepted doorbell strobe |
| notifyDest | output | 16 | Destination of accepted doorbell |
| notifyVec | output | 8 | Vector of accepted doorbell |

## Verification
The bench uses the defaults NUM_PEERS=4 and CNT_W=9. A 9-bit count can reach 256, so vector 255 can be accepted, and a count of 0 blocks every vector. With peerCount driven up to 6, destinations fall beyond peerCount, and also inside peerCount but beyond the four-entry count table, which covers both halves of the destination check. Random traffic mixes event injections into status reads and writes to reach the priority case, and fills the junk address bits and doorbell middle byte.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2,
    RD_POS    = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrStatus;
    logic   rdStatus;
    logic   ringBell;
    rdSel_e rdSel;
  } regStrobes_t;

  localparam int IDX_MASK   = 0;
  localparam int IDX_STATUS = 1;
  localparam int IDX_POS    = 2;
  localparam int IDX_BELL   = 3;
endpackage

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       strobes
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             isWr;
  logic             isRd;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign isWr    = busSel && busWrite;
  assign isRd    = busSel && !busWrite;

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    if (isWr) begin
      strobes.wrMask   = (wordIdx == IDX_W'(IDX_MASK));
      strobes.wrStatus = (wordIdx == IDX_W'(IDX_STATUS));
      strobes.ringBell = (wordIdx == IDX_W'(IDX_BELL));
    end
    if (isRd) begin
      if (wordIdx == IDX_W'(IDX_MASK))        strobes.rdSel = RD_MASK;
      else if (wordIdx == IDX_W'(IDX_STATUS)) strobes.rdSel = RD_STATUS;
      else if (wordIdx == IDX_W'(IDX_POS))    strobes.rdSel = RD_POS;
      strobes.rdStatus = (wordIdx == IDX_W'(IDX_STATUS));
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMask, strobes.wrStatus, strobes.rdStatus, strobes.ringBell})); // R1
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (strobes.rdSel == RD_NONE && !strobes.ringBell)); // R1
endmodule

// File: rtl/dbr_doorbell.sv
module dbr_doorbell #(
  parameter int NUM_PEERS = 4,
  parameter int CNT_W     = 9,
  parameter int ID_W      = 16,
  parameter int VEC_W     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ringBell,
  input  logic [ID_W-1:0]        bellDest,
  input  logic [VEC_W-1:0]       bellVec,
  input  logic [ID_W-1:0]        peerCount,
  input  logic [NUM_PEERS*CNT_W-1:0] peerVecCnt,
  output logic                   notifyPulse,
  output logic [ID_W-1:0]        notifyDest,
  output logic [VEC_W-1:0]       notifyVec
);
  localparam int PIDX_W = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
  localparam int CMP_W  = (CNT_W > VEC_W) ? CNT_W : VEC_W;

  logic [CNT_W-1:0] cntTable [NUM_PEERS];
  logic [CNT_W-1:0] selCnt;
  logic             destInTable;
  logic             destLive;
  logic             vecLive;

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_cnt
    assign cntTable[p] = peerVecCnt[p*CNT_W +: CNT_W];
  end

  assign destInTable = (bellDest < ID_W'(NUM_PEERS));
  assign destLive    = destInTable && (bellDest < peerCount);
  assign selCnt      = destInTable ? cntTable[bellDest[PIDX_W-1:0]] : '0;
  assign vecLive     = (CMP_W'(bellVec) < CMP_W'(selCnt));

  assign notifyPulse = ringBell && destLive && vecLive;
  assign notifyDest  = notifyPulse ? bellDest : '0;
  assign notifyVec   = notifyPulse ? bellVec  : '0;

  AST_BELL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    notifyPulse |-> ringBell); // R5
  AST_BELL_DEST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    notifyPulse |-> (notifyDest < peerCount)); // R6
  AST_BELL_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    !notifyPulse |-> (notifyDest == '0 && notifyVec == '0)); // R5
endmodule

// File: rtl/dbr_datapath.sv
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 16,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              regionMapped,
  input  logic [ID_W-1:0]   localId,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtByte,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] posWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strobes.wrMask) maskQ <= busWdata;
      if (evtValid)              statusQ <= DATA_W'(evtByte);
      else if (strobes.wrStatus) statusQ <= busWdata;
      else if (strobes.rdStatus) statusQ <= '0;
    end
  end

  assign irq     = |(statusQ & maskQ);
  assign posWord = regionMapped ? DATA_W'(localId) : '1;

  always_comb begin
    unique case (strobes.rdSel)
      RD_MASK:   busRdata = maskQ;
      RD_STATUS: busRdata = statusQ;
      RD_POS:    busRdata = posWord;
      default:   busRdata = '0;
    endcase
  end

  AST_EVT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> (statusQ == DATA_W'($past(evtByte)))); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStatus && !evtValid) |=> (statusQ == '0 && !irq)); // R4
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrMask && busWdata == '0) |=> !irq); // R3
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrMask |=> $stable(maskQ)); // R9
endmodule

// File: rtl/doorbell_irq_regs.sv
module doorbell_irq_regs
  import dbr_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int CNT_W     = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [7:0]                 busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic [15:0]                peerCount,
  input  logic [NUM_PEERS*CNT_W-1:0] peerVecCnt,
  input  logic                       regionMapped,
  input  logic [15:0]                localId,
  input  logic                       evtValid,
  input  logic [7:0]                 evtByte,
  output logic                       irq,
  output logic                       notifyPulse,
  output logic [15:0]                notifyDest,
  output logic [7:0]                 notifyVec
);
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;
  localparam int VEC_W  = 8;

  regStrobes_t strobes;
  logic        unusedBits;

  assign unusedBits = ^{busWdata[15:8], busAddr[1:0]};

  dbr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  dbr_datapath #(.DATA_W(DATA_W), .ID_W(ID_W), .EVT_W(8)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busWdata     (busWdata),
    .regionMapped (regionMapped),
    .localId      (localId),
    .evtValid     (evtValid),
    .evtByte      (evtByte),
    .busRdata     (busRdata),
    .irq          (irq)
  );

  dbr_doorbell #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W), .ID_W(ID_W), .VEC_W(VEC_W)) u_bell (
    .clk         (clk),
    .rstN        (rstN),
    .ringBell    (strobes.ringBell),
    .bellDest    (busWdata[31:16]),
    .bellVec     (busWdata[7:0]),
    .peerCount   (peerCount),
    .peerVecCnt  (peerVecCnt),
    .notifyPulse (notifyPulse),
    .notifyDest  (notifyDest),
    .notifyVec   (notifyVec)
  );
endmodule

// File: tb/doorbell_irq_regs_test.sv
`timescale 1ns/1ps
module doorbell_irq_regs_test;
  localparam int NP = 4;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] peerCount = 16'd2;
  logic [CW-1:0] cnt [NP];
  logic [NP*CW-1:0] peerVecCnt;
  logic regionMapped = 1'b0;
  logic [15:0] localId = 16'h0005;
  logic evtValid = 1'b0;
  logic [7:0] evtByte = '0;
  logic irq, notifyPulse;
  logic [15:0] notifyDest;
  logic [7:0] notifyVec;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [31:0] mMask = '0, mStatus = '0;

  always #2.5 clk = ~clk;
  assign peerVecCnt = {cnt[3], cnt[2], cnt[1], cnt[0]};

  doorbell_irq_regs #(.NUM_PEERS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .peerCount(peerCount), .peerVecCnt(peerVecCnt),
    .regionMapped(regionMapped), .localId(localId), .evtValid(evtValid), .evtByte(evtByte),
    .irq(irq), .notifyPulse(notifyPulse), .notifyDest(notifyDest), .notifyVec(notifyVec));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit bellOk(input logic [15:0] d, input logic [7:0] v);
    if (d >= peerCount || d >= 16'(NP)) return 0;
    return ({1'b0, v} < 9'(cnt[d[1:0]]));
  endfunction

  function automatic logic [31:0] expRead(input logic [5:0] idx);
    case (idx)
      6'd0: return mMask;
      6'd1: return mStatus;
      6'd2: return regionMapped ? {16'h0, localId} : 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  // One bus cycle (or idle if sel=0); checks combinational outputs then irq after the edge.
  task automatic access(input bit sel, input bit wr, input logic [7:0] addr,
                        input logic [31:0] data, input bit evt, input logic [7:0] eb,
                        input string tag);
    logic [5:0] idx;
    bit ok;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = addr; busWdata = data;
    evtValid = evt; evtByte = eb;
    idx = addr[7:2];
    #1;
    if (sel && !wr) check({tag, " R1 rdata"}, busRdata, expRead(idx));
    else check({tag, " R1 rdata idle"}, busRdata, 32'h0);
    ok = sel && wr && idx == 6'd3 && bellOk(data[31:16], data[7:0]);
    check({tag, " R5 pulse"}, {31'h0, notifyPulse}, {31'h0, ok});
    check({tag, " R6 R7 dest/vec"}, {8'h0, notifyDest, notifyVec},
          ok ? {8'h0, data[31:16], data[7:0]} : 32'h0);
    @(posedge clk);
    if (sel && wr && idx == 6'd0) mMask = data;
    if (evt) mStatus = {24'h0, eb};
    else if (sel && wr && idx == 6'd1) mStatus = data;
    else if (sel && !wr && idx == 6'd1) mStatus = 32'h0;
    #1;
    check({tag, " R3 irq"}, {31'h0, irq}, {31'h0, |(mMask & mStatus)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    cnt[0] = 9'd1; cnt[1] = 9'd3; cnt[2] = 9'd5; cnt[3] = 9'd256;
    repeat (3) @(posedge clk);
    #1; check("R2 irq in reset", {31'h0, irq}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    access(1, 0, 8'h00, 0, 0, 0, "R2 mask after reset");
    access(1, 0, 8'h04, 0, 0, 0, "R2 status after reset");

    // R3/R4: set cause, enable, read clears
    access(1, 1, 8'h04, 32'h0000_0101, 0, 0, "R3 set status");
    access(1, 1, 8'h00, 32'h0000_0100, 0, 0, "R3 mask hit");
    access(1, 0, 8'h06, 0, 0, 0, "R4 read clears, low bits ignored");
    access(1, 0, 8'h04, 0, 0, 0, "R4 status now zero");
    // R10 event, R11 priority over read and write
    access(1, 0, 8'h04, 0, 1, 8'hA5, "R11 read+event");
    access(1, 0, 8'h04, 0, 0, 0, "R11 event survived read");
    access(1, 1, 8'h04, 32'hDEAD_BEEF, 1, 8'h3C, "R11 write+event");
    access(1, 0, 8'h04, 0, 0, 0, "R10 status zero-extended byte");
    // R8 position
    access(1, 0, 8'h08, 0, 0, 0, "R8 unmapped all ones");
    @(negedge clk); regionMapped = 1'b1;
    access(1, 0, 8'h09, 0, 0, 0, "R8 mapped id");
    // R9 undefined and position writes
    access(1, 1, 8'h08, 32'hFFFF_FFFF, 0, 0, "R9 pos write");
    access(1, 1, 8'hFC, 32'hFFFF_FFFF, 0, 0, "R9 undefined write");
    access(1, 0, 8'h40, 0, 0, 0, "R9 undefined read");
    access(1, 0, 8'h00, 0, 0, 0, "R9 mask unchanged");
    // R5/R6/R7 doorbell boundaries
    @(negedge clk); peerCount = 16'd3;
    access(1, 1, 8'h0C, 32'h0002_FF04, 0, 0, "R5 R7 dest2 vec4 ok, mid byte junk");
    access(1, 1, 8'h0C, 32'h0002_0005, 0, 0, "R7 vec == count dropped");
    access(1, 1, 8'h0C, 32'h0003_0000, 0, 0, "R6 dest == peerCount dropped");
    @(negedge clk); peerCount = 16'd6;
    access(1, 1, 8'h0D, 32'h0003_00FF, 0, 0, "R7 count 256 vec 255 ok");
    access(1, 1, 8'h0C, 32'h0004_0000, 0, 0, "R6 beyond table dropped");
    @(negedge clk); cnt[1] = 9'd0;
    access(1, 1, 8'h0C, 32'h0001_0000, 0, 0, "R7 zero count dropped");

    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = $urandom();
      if ($urandom_range(0, 19) == 0) begin
        @(negedge clk);
        peerCount = 16'($urandom_range(0, 6));
        regionMapped = 1'($urandom());
        localId = 16'($urandom());
        for (int p = 0; p < NP; p++) cnt[p] = 9'($urandom_range(0, 256));
      end
      case (op)
        0, 1:    a = {6'd0, 2'($urandom())};
        2, 3:    a = {6'd1, 2'($urandom())};
        4:       a = {6'd2, 2'($urandom())};
        5, 6, 7: begin
          a = {6'd3, 2'($urandom())};
          d = {16'($urandom_range(0, 6)), 8'($urandom()), 8'($urandom_range(0, 9))};
          if ($urandom_range(0, 3) == 0) d[7:0] = 8'($urandom());
        end
        default: a = {6'($urandom_range(4, 63)), 2'($urandom())};
      endcase
      access($urandom_range(0, 9) != 0, 1'($urandom()), a, d,
             $urandom_range(0, 4) == 0, 8'($urandom()), "random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule